// File: doc/BRIEF.md
# Flash Program Sequence Controller

This block sits between a register bus and an embedded flash array and governs how a page gets programmed. Software raises a program-mode bit, streams array writes into a 256-bit page buffer, then sets a high-voltage start bit. The controller decides whether the gathered writes form a legal program and, if so, hands the merged page and a per-segment mask to the array over a start/done handshake. When the array finishes, or as soon as a rule is broken, a done flag rises with a pass flag that tells the two outcomes apart.

The first accepted array write of a session is the interlock write. It pins the page and the address space (normal or shadow) for that session. Later writes in the same page overwrite or extend the buffer. ECC is kept per 64-bit segment, which is two 32-bit words. Each segment the program touches must be completely written, and a segment that was programmed once may not be programmed again. A record of programmed segments is kept per page and per space from reset onward.

Array writes come in on a valid/ready stream. `wr_ready` is low only while the array is running a program. A write offered then simply waits. A write accepted while program mode is off, or while the start bit is set, is consumed and dropped. The control and status pins are plain levels.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, `st_pgm`, `st_ehv`, `st_done`, `st_pass`, `st_shadow` and `arr_start` are all 0, and no segment is recorded as programmed.
- R2: Program mode is entered by a control write that moves the mode bit from 0 to 1. A control write that sets the start bit while no interlock write has been taken, or while program mode is off, is ignored: `st_ehv`, `st_done` and `arr_start` stay 0.
- R3: The interlock write fixes the page (address bits above the low three) and the space. `st_shadow` shows that space from the next cycle on, and the array receives the same page and space.
- R4: In `arr_data`, word i occupies bits [32i+31:32i]. Words that were not written are 0xFFFFFFFF. When a word is written more than once, the last value is used. A doubleword write puts `wr_data[31:0]` at the even word and `wr_data[63:32]` at the odd word above it.
- R5: When every touched segment is fully written, setting the start bit issues one `arr_start` pulse, with `arr_seg_mask` bit s set for each touched segment s (words 2s and 2s+1). `st_done` and `st_pass` rise together in the cycle after `arr_done`.
- R6: If any touched segment has only one of its two words written, setting the start bit makes `st_done` 1 with `st_pass` 0 in the next cycle, and no `arr_start` is issued.
- R7: A doubleword write at an odd word address, or any write after the interlock that targets another page or the other space, makes the operation fail as in R6.
- R8: A program that touches a segment already programmed in the same page and space fails as in R6. Other segments of that page remain programmable.
- R9: Clearing the mode bit before the start bit is set ends the session with no `arr_start`. The buffered writes and the interlock are discarded.
- R10: Clearing the start bit after done clears `st_done` and `st_pass`. Program mode stays on, and the next accepted write is a fresh interlock write.
- R11: Array writes accepted while the start bit is set are ignored. They do not count as an interlock for the next session.
- R12: `arr_start` lasts exactly one cycle. While the array is busy, `wr_ready` is 0 and a control write clearing the start bit is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_pgm | input | 1 | Program-mode bit value written |
| ctl_ehv | input | 1 | Start bit value written |
| st_pgm | output | 1 | Program mode active |
| st_ehv | output | 1 | Start bit |
| st_done | output | 1 | Operation finished |
| st_pass | output | 1 | Operation succeeded (valid with done) |
| st_shadow | output | 1 | Space chosen by the interlock write (1 = shadow) |
| wr_valid | input | 1 | Array write offered |
| wr_ready | output | 1 | Array write can be taken |
| wr_addr | input | AW | Word address: page in high bits, word index in low 3 bits |
| wr_data | input | 64 | Write data (low 32 bits used for a word write) |
| wr_dw | input | 1 | 1 = doubleword write |
| wr_shadow | input | 1 | Target space of the write (1 = shadow) |
| arr_start | output | 1 | One-cycle program request to the array |
| arr_page | output | AW-3 | Page to program |
| arr_shadow | output | 1 | Space to program |
| arr_data | output | 256 | Merged page data |
| arr_seg_mask | output | 4 | Segments to program |
| arr_done | input | 1 | Array finished the program |

## Verification
A wrong write mask or a stale buffer word would show up in `arr_data` and `arr_seg_mask` on the very cycle `arr_start` pulses. A wrong rule decision would show up as the wrong `st_pass` one cycle after the start bit is set. A lost or spurious interlock would show up as the start bit being taken or refused. A corrupted programmed-segment record stays hidden until a later program hits the same segment, so the bench revisits pages and segments after programming them. An exhaustive sweep of all 256 word-write patterns on rotating pages and spaces covers the fill rule and the data merge.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
  localparam int WORD_W     = 32;
  localparam int SEG_WORDS  = 2;
  localparam int PAGE_SEGS  = 4;
  localparam int PAGE_WORDS = SEG_WORDS * PAGE_SEGS;
  localparam int PAGE_BITS  = WORD_W * PAGE_WORDS;
  localparam int IDX_W      = $clog2(PAGE_WORDS);
  localparam int DW_W       = 2 * WORD_W;
endpackage

// File: rtl/flash_pgbuf.sv
module flash_pgbuf
  import flash_prog_pkg::*;
#(
  parameter int AW = 5,
  localparam int PG_W = AW - IDX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [DW_W-1:0]       wr_data,
  input  logic                  wr_dw,
  input  logic                  wr_space,
  output logic                  ilk,
  output logic [PG_W-1:0]       page,
  output logic                  space,
  output logic [PAGE_BITS-1:0]  data,
  output logic [PAGE_WORDS-1:0] wmask,
  output logic                  err
);
  logic [WORD_W-1:0] words [PAGE_WORDS];
  logic [IDX_W-1:0]  idx;
  logic [PG_W-1:0]   pg;
  logic              off_page, misal;

  assign idx      = wr_addr[IDX_W-1:0];
  assign pg       = wr_addr[AW-1:IDX_W];
  assign off_page = ilk && ((pg != page) || (wr_space != space));
  assign misal    = wr_dw && idx[0];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      ilk   <= 1'b0;
      page  <= '0;
      space <= 1'b0;
      wmask <= '0;
      err   <= 1'b0;
      for (int w = 0; w < PAGE_WORDS; w++) words[w] <= '1;
    end else if (wr_en) begin
      if (!ilk) begin
        ilk   <= 1'b1;
        page  <= pg;
        space <= wr_space;
      end
      if (off_page || misal) begin
        err <= 1'b1;
      end else begin
        for (int w = 0; w < PAGE_WORDS; w++) begin
          if (IDX_W'(w) == idx) begin
            words[w] <= wr_data[WORD_W-1:0];
            wmask[w] <= 1'b1;
          end
          if (wr_dw && IDX_W'(w) == {idx[IDX_W-1:1], 1'b1}) begin
            words[w] <= wr_data[DW_W-1:WORD_W];
            wmask[w] <= 1'b1;
          end
        end
      end
    end
  end

  for (genvar g = 0; g < PAGE_WORDS; g++) begin : g_flat
    assign data[g*WORD_W +: WORD_W] = words[g];
  end
endmodule

// File: rtl/flash_seg_map.sv
module flash_seg_map
  import flash_prog_pkg::*;
#(
  parameter int NPG = 8,
  localparam int SEL_W = $clog2(NPG)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PAGE_WORDS-1:0] wmask,
  input  logic [SEL_W-1:0]      sel,
  input  logic                  commit,
  output logic [PAGE_SEGS-1:0]  touched,
  output logic                  rule_ok
);
  logic [PAGE_SEGS-1:0] prog [NPG];
  logic [PAGE_SEGS-1:0] full;

  for (genvar s = 0; s < PAGE_SEGS; s++) begin : g_seg
    assign touched[s] = |wmask[s*SEG_WORDS +: SEG_WORDS];
    assign full[s]    = &wmask[s*SEG_WORDS +: SEG_WORDS];
  end

  assign rule_ok = (touched != '0) && (touched == full) &&
                   ((touched & prog[sel]) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NPG; p++) prog[p] <= '0;
    end else if (commit) begin
      prog[sel] <= prog[sel] | touched;
    end
  end
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_prog_pkg::*;
#(
  parameter int AW = 5,
  localparam int PG_W = AW - IDX_W,
  localparam int NPG  = 2 << PG_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctl_wr,
  input  logic                  ctl_pgm,
  input  logic                  ctl_ehv,
  output logic                  st_pgm,
  output logic                  st_ehv,
  output logic                  st_done,
  output logic                  st_pass,
  output logic                  st_shadow,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  input  logic [AW-1:0]         wr_addr,
  input  logic [DW_W-1:0]       wr_data,
  input  logic                  wr_dw,
  input  logic                  wr_shadow,
  output logic                  arr_start,
  output logic [PG_W-1:0]       arr_page,
  output logic                  arr_shadow,
  output logic [PAGE_BITS-1:0]  arr_data,
  output logic [PAGE_SEGS-1:0]  arr_seg_mask,
  input  logic                  arr_done
);
  logic busy, ilk, err, rule_ok, buf_clr, commit, wr_acc;
  logic [PG_W-1:0]       page;
  logic                  space;
  logic [PAGE_WORDS-1:0] wmask;

  assign wr_ready = !busy;
  assign wr_acc   = wr_valid && wr_ready && st_pgm && !st_ehv;
  assign commit   = busy && arr_done;
  assign buf_clr  = ctl_wr && (st_ehv ? (!ctl_ehv && !busy) : (ctl_pgm != st_pgm));

  flash_pgbuf #(.AW(AW)) u_buf (
    .clk, .rst_n, .clr(buf_clr), .wr_en(wr_acc), .wr_addr, .wr_data, .wr_dw,
    .wr_space(wr_shadow), .ilk, .page, .space, .data(arr_data), .wmask, .err
  );

  flash_seg_map #(.NPG(NPG)) u_map (
    .clk, .rst_n, .wmask, .sel({space, page}), .commit,
    .touched(arr_seg_mask), .rule_ok
  );

  assign arr_page   = page;
  assign arr_shadow = space;
  assign st_shadow  = space;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_pgm    <= 1'b0;
      st_ehv    <= 1'b0;
      st_done   <= 1'b0;
      st_pass   <= 1'b0;
      busy      <= 1'b0;
      arr_start <= 1'b0;
    end else begin
      arr_start <= 1'b0;
      if (commit) begin
        busy    <= 1'b0;
        st_done <= 1'b1;
        st_pass <= 1'b1;
      end
      if (ctl_wr) begin
        if (!st_ehv) begin
          if (ctl_pgm != st_pgm) begin
            st_pgm <= ctl_pgm;
          end else if (ctl_ehv && st_pgm && ilk) begin
            st_ehv <= 1'b1;
            if (rule_ok && !err) begin
              arr_start <= 1'b1;
              busy      <= 1'b1;
            end else begin
              st_done <= 1'b1;
              st_pass <= 1'b0;
            end
          end
        end else if (!ctl_ehv && !busy) begin
          st_ehv  <= 1'b0;
          st_done <= 1'b0;
          st_pass <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic st_pgm,
  input logic st_ehv,
  input logic st_done,
  input logic st_pass,
  input logic arr_start,
  input logic arr_done
);
  // R5
  pass_implies_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_pass |-> st_done);
  // R2
  start_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_start |-> (st_ehv && st_pgm));
  // R9
  ehv_needs_pgm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st_pgm |-> !st_ehv);
  // R12
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_start |=> !arr_start);
  // R5
  pass_after_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(st_done) && st_pass) |-> $past(arr_done));
  // R10
  ehv_clear_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_ehv) |-> (!st_done && !st_pass));
endmodule

bind flash_prog_seq flash_prog_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st_pgm(st_pgm), .st_ehv(st_ehv),
  .st_done(st_done), .st_pass(st_pass), .arr_start(arr_start), .arr_done(arr_done)
);

// File: tb/flash_prog_seq_bench.sv
module flash_prog_seq_bench;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 1'b0, ctl_pgm = 1'b0, ctl_ehv = 1'b0;
  logic st_pgm, st_ehv, st_done, st_pass, st_shadow;
  logic wr_valid = 1'b0, wr_dw = 1'b0, wr_shadow = 1'b0;
  logic wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [63:0]   wr_data = '0;
  logic arr_start, arr_shadow;
  logic [AW-4:0] arr_page;
  logic [255:0]  arr_data;
  logic [3:0]    arr_seg_mask;
  logic arr_done = 1'b0;

  int checks = 0, fails = 0, starts = 0, cnt = 0;
  bit finished = 1'b0;
  logic [255:0] cap_data;
  logic [3:0]   cap_mask;
  logic [AW-4:0] cap_page;
  logic         cap_shadow;

  always #5 clk = ~clk;

  flash_prog_seq #(.AW(AW)) u_flash_prog_seq (.*);

  // behavioural array: answers after a few cycles
  always @(posedge clk) begin
    arr_done <= 1'b0;
    if (arr_start) begin
      starts     <= starts + 1;
      cap_data   <= arr_data;
      cap_mask   <= arr_seg_mask;
      cap_page   <= arr_page;
      cap_shadow <= arr_shadow;
      cnt        <= 3;
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) arr_done <= 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctl(input logic p, input logic e);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_pgm = p; ctl_ehv = e;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic wr(input int addr, input logic [63:0] d, input logic dw, input logic sp);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = AW'(addr); wr_data = d; wr_dw = dw; wr_shadow = sp;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // start, wait for completion, check pass flag and start count
  task automatic run_expect(input bit exp_pass, input string req);
    int s0;
    s0 = starts;
    ctl(1'b1, 1'b1);
    settle(8);
    check(st_done == 1'b1 && st_pass == exp_pass, req, {st_done, st_pass}, {1'b1, exp_pass});
    check((starts - s0) == (exp_pass ? 1 : 0), req, 256'(starts - s0), 256'(exp_pass ? 1 : 0));
  endtask

  function automatic logic [255:0] fill(input logic [255:0] d, input int w, input logic [31:0] v);
    logic [255:0] r;
    r = d;
    r[w*32 +: 32] = v;
    return r;
  endfunction

  initial begin
    int timer;
    timer = 0;
    while (!finished) begin
      @(posedge clk);
      timer++;
      if (timer > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", timer);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [255:0] exp;
    do_reset();
    @(negedge clk);
    // R1 reset values
    check({st_pgm, st_ehv, st_done, st_pass, st_shadow, arr_start} == 6'b0, "R1",
          {st_pgm, st_ehv, st_done, st_pass, st_shadow, arr_start}, 0);
    // R2 start bit without program mode is ignored
    ctl(1'b0, 1'b1);
    settle(2);
    check(st_ehv == 1'b0 && st_done == 1'b0 && starts == 0, "R2", {st_ehv, st_done}, 0);

    // exhaustive word-write patterns: R3 R4 R5 R6 R2
    for (int pat = 0; pat < 256; pat++) begin
      int pg;
      logic sp;
      bit legal;
      int s0;
      pg = pat % 4;
      sp = pat[0] ^ pat[7];
      do_reset();
      ctl(1'b1, 1'b0);
      exp = '1;
      for (int w = 0; w < 8; w++) begin
        if (pat[w]) begin
          wr(pg * 8 + w, {32'h0, 32'hA000_0000 | (pat << 8) | w}, 1'b0, sp);
          exp = fill(exp, w, 32'hA000_0000 | (pat << 8) | w);
        end
      end
      legal = pat != 0;
      for (int s = 0; s < 4; s++) if (pat[2*s] != pat[2*s+1]) legal = 0;
      s0 = starts;
      ctl(1'b1, 1'b1);
      settle(8);
      if (pat == 0) begin
        check(st_ehv == 1'b0 && st_done == 1'b0 && starts == s0, "R2 no interlock",
              {st_ehv, st_done}, 0);
      end else if (legal) begin
        logic [3:0] em;
        for (int s = 0; s < 4; s++) em[s] = pat[2*s];
        check(st_done && st_pass && starts == s0 + 1, "R5 pass", {st_done, st_pass}, 2'b11);
        check(cap_data == exp, "R4 merged data", cap_data, exp);
        check(cap_mask == em, "R5 seg mask", cap_mask, em);
        check(cap_page == pg[1:0] && cap_shadow == sp && st_shadow == sp, "R3 page/space",
              {cap_page, cap_shadow, st_shadow}, {pg[1:0], sp, sp});
      end else begin
        check(st_done && !st_pass && starts == s0, "R6 partial segment",
              {st_done, st_pass, 8'(starts - s0)}, {2'b10, 8'h0});
      end
    end

    // R4 doubleword placement and last-write-wins
    do_reset();
    ctl(1'b1, 1'b0);
    wr(2, 64'hBBBB_0002_AAAA_0002, 1'b1, 1'b0);
    wr(3, 64'h0000_0000_CCCC_0003, 1'b0, 1'b0);
    run_expect(1'b1, "R4 dw");
    exp = fill(fill('1, 2, 32'hAAAA_0002), 3, 32'hCCCC_0003);
    check(cap_data == exp, "R4 last write", cap_data, exp);
    check(cap_mask == 4'b0010, "R5 dw mask", cap_mask, 4'b0010);
    // R10 clearing start
    ctl(1'b1, 1'b0);
    settle(1);
    check({st_pgm, st_ehv, st_done, st_pass} == 4'b1000, "R10", {st_pgm, st_ehv, st_done, st_pass}, 4'b1000);
    // R8 program once
    wr(2, 64'h1111_1111_2222_2222, 1'b1, 1'b0);
    run_expect(1'b0, "R8 reprogram");
    ctl(1'b1, 1'b0);
    wr(0, 64'h3333_3333_4444_4444, 1'b1, 1'b0);
    run_expect(1'b1, "R8 other segment");
    ctl(1'b1, 1'b0);
    wr(2, 64'h5555_5555_6666_6666, 1'b1, 1'b1);
    run_expect(1'b1, "R8 other space");
    ctl(1'b1, 1'b0);

    // R7 misaligned doubleword, off-page, off-space
    wr(13, 64'h7, 1'b1, 1'b0);
    run_expect(1'b0, "R7 misaligned");
    ctl(1'b1, 1'b0);
    wr(8, 64'h8, 1'b0, 1'b0);
    wr(9, 64'h9, 1'b0, 1'b0);
    wr(16, 64'h1_0000_0010, 1'b1, 1'b0);
    run_expect(1'b0, "R7 off page");
    ctl(1'b1, 1'b0);
    wr(8, 64'h8, 1'b0, 1'b0);
    wr(9, 64'h9, 1'b0, 1'b1);
    run_expect(1'b0, "R7 off space");
    ctl(1'b1, 1'b0);

    // R9 terminate before start
    wr(24, 64'h2_0000_0001, 1'b1, 1'b0);
    ctl(1'b0, 1'b0);
    check(st_pgm == 1'b0, "R9 mode off", st_pgm, 0);
    ctl(1'b1, 1'b0);
    ctl(1'b1, 1'b1);
    settle(6);
    check(st_ehv == 1'b0 && st_done == 1'b0, "R9 interlock discarded", {st_ehv, st_done}, 0);
    wr(24, 64'h2_0000_0001, 1'b1, 1'b0);
    run_expect(1'b1, "R9 segment untouched");

    // R11 writes while start set are ignored
    wr(30, 64'hDEAD_BEEF_0000_0000, 1'b1, 1'b0);
    ctl(1'b1, 1'b0);
    ctl(1'b1, 1'b1);
    settle(6);
    check(st_ehv == 1'b0 && st_done == 1'b0, "R11", {st_ehv, st_done}, 0);

    // R12 ready low and start-clear ignored while busy
    wr(30, 64'hE, 1'b1, 1'b0);
    ctl(1'b1, 1'b1);
    check(wr_ready == 1'b0, "R12 ready", wr_ready, 0);
    ctl(1'b1, 1'b0);
    check(st_ehv == 1'b1, "R12 clear ignored", st_ehv, 1);
    settle(6);
    check(st_done && st_pass && wr_ready, "R12 completes", {st_done, st_pass, wr_ready}, 3'b111);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    finished = 1'b1;
    $finish;
  end
endmodule